// File: doc/BRIEF.md
# Reload/Compare Timer with Capture

This block is a 16-bit up-counter with two modes and three input-capture channels. A run bit gates it, and a prescaler clocks it from the system clock. A mode bit selects the mode. In reload mode, a 16-bit reload register is copied into the counter when a selected event occurs. That event is either a counter wrap from FFFFh or a capture on one chosen channel. In compare mode, the same register holds a match value: a match sets the timer flag and can optionally send the counter back to zero.

Each capture channel passes its pin through a two-flop synchronizer and an optional 4-clock stability filter. It then detects the configured edge, copies the counter into its own 16-bit capture register and sets a sticky flag. A separate option makes any capture clear the counter instead of reloading it. Software reaches every register through a byte-wide write/read port with a 4-bit address.

Top module: `rcap_timer`

## Requirements
- R1: After reset, every register reads 00h, both flag outputs are low, and the counter is 0000h.
- R2: The counter advances by one only on a prescaler tick, and ticks occur only while the run bit is set. Divide field values 0..7 give one tick every 1, 4, 16, 32, 64, 128, 256 or 512 clocks. While the run bit is clear, the counter holds its value.
- R3: In reload mode (mode bit 0), a tick at FFFFh sets the timer flag. The counter then loads the reload value if reload-enable is set and trigger-select is 00; otherwise it goes to 0000h.
- R4: In reload mode with reload-enable set, trigger-select 01, 10 or 11 loads the reload value into the counter on a capture event of channel 0, 1 or 2 respectively.
- R5: With the capture-clear bit set, a capture event on any enabled channel clears the counter to 0000h. This takes priority over any reload.
- R6: In compare mode (mode bit 1), the timer flag is set on the tick that makes the counter equal to the compare register.
- R7: In compare mode with compare-clear set, a tick taken while the counter equals the compare register sends it to 0000h instead of incrementing it.
- R8: An enabled channel takes a qualified edge, stores the counter value into its capture register and sets its flag. The edge field selects the edge: 00 falling, 01 rising, 10 both, 11 none. A disabled channel ignores its pin.
- R9: The pins are synchronized through two flops. With the filter enabled, a level change is accepted only after it has been stable for 4 consecutive synchronized samples, so shorter pulses are ignored.
- R10: Flags are sticky. Writing 0 to a flag bit clears it, and writing 1 has no effect. A set in the same cycle as a clearing write wins.
- R11: Register map. Each write takes effect on the following edge, and a counter write overrides counting in that cycle.
  - 0: control {flag[7], compare-clear[4], capture-clear[3], reload-enable[2], mode[1], run[0]}
  - 1: {trigger-select[5:4], divide[2:0]}
  - 2/3: counter low/high
  - 4/5: reload/compare low/high
  - 6..8: channel config {edge[3:2], filter[1], enable[0]}
  - 9: capture flags[2:0]
  - 10..15: capture registers, low then high for channels 0, 1, 2

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| cap_in | input | 3 | Capture pins, one per channel |
| tmr_flag | output | 1 | Timer overflow/match flag |
| cap_flag | output | 3 | Capture flags |

## Verification
The hardest case to reach is a timer-flag set that lands in the same clock as a software write clearing that flag. The stimulus makes this happen by stopping the timer and preloading FFFEh. It then restarts at divide-by-one and issues the clearing write exactly two clocks later, the clock in which the wrap occurs. A second hard case is a pulse that lasts longer than the synchronizer but shorter than the filter window. The bench drives pulses of 2 and 6 clocks into a filtered channel. In both cases, a behavioural model advanced every clock decides what must be seen.

// File: rtl/rcap_timer.sv
module rcap_timer #(
  parameter int FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [2:0] cap_in,
  output logic       tmr_flag,
  output logic [2:0] cap_flag
);
  localparam int HW = FILT_LEN - 1;

  logic        run, mode, rld_en, cap_clr, cmp_clr, tflag;
  logic [2:0]  div;
  logic [1:0]  trig;
  logic [15:0] cnt, rld, cnt_n;
  logic [8:0]  pre, lim;
  logic [3:0]  ccfg [3];
  logic [15:0] capv [3];
  logic [2:0]  capf, ev;
  logic        tick, tset, wr_cnt;
  logic [3:0]  trig_ev;

  always_comb begin
    case (div)
      3'd0:    lim = 9'd0;
      3'd1:    lim = 9'd3;
      default: lim = 9'((32'd1 << (32'(div) + 32'd2)) - 32'd1);
    endcase
  end

  assign tick    = run && (pre >= lim);
  assign wr_cnt  = wr_en && (addr == 4'd2 || addr == 4'd3);
  assign trig_ev = {ev, 1'b0};

  genvar g;
  for (g = 0; g < 3; g++) begin : g_ch
    logic s1, s2, lvl, nlvl;
    logic [HW-1:0] hist;
    wire stable = (hist == {HW{s2}});
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        s1 <= 1'b0; s2 <= 1'b0; lvl <= 1'b0; hist <= '0;
      end else begin
        s1   <= cap_in[g];
        s2   <= s1;
        hist <= (hist << 1) | HW'(s2);
        lvl  <= nlvl;
      end
    assign nlvl = (ccfg[g][1] && !stable) ? lvl : s2;
    always_comb
      case (ccfg[g][3:2])
        2'b00:   ev[g] = ccfg[g][0] && (lvl && !nlvl);
        2'b01:   ev[g] = ccfg[g][0] && (!lvl && nlvl);
        2'b10:   ev[g] = ccfg[g][0] && (lvl != nlvl);
        default: ev[g] = 1'b0;
      endcase
  end

  always_comb begin
    cnt_n = cnt;
    tset  = 1'b0;
    if (wr_cnt) begin
      if (addr == 4'd2) cnt_n[7:0]  = wdata;
      else              cnt_n[15:8] = wdata;
    end else if (cap_clr && ev != 3'b000) begin
      cnt_n = 16'h0000;
    end else if (!mode && rld_en && trig != 2'b00 && trig_ev[trig]) begin
      cnt_n = rld;
    end else if (tick) begin
      if (!mode) begin
        if (cnt == 16'hFFFF) begin
          tset  = 1'b1;
          cnt_n = (rld_en && trig == 2'b00) ? rld : 16'h0000;
        end else begin
          cnt_n = cnt + 16'd1;
        end
      end else begin
        cnt_n = (cmp_clr && cnt == rld) ? 16'h0000 : cnt + 16'd1;
        tset  = (cnt_n == rld);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {run, mode, rld_en, cap_clr, cmp_clr, tflag} <= '0;
      div <= '0; trig <= '0; cnt <= '0; rld <= '0; pre <= '0; capf <= '0;
      for (int i = 0; i < 3; i++) begin
        ccfg[i] <= '0;
        capv[i] <= '0;
      end
    end else begin
      pre <= (!run || tick) ? 9'd0 : pre + 9'd1;
      cnt <= cnt_n;
      tflag <= tset | (tflag & !(wr_en && addr == 4'd0 && !wdata[7]));
      for (int i = 0; i < 3; i++) begin
        if (ev[i]) capv[i] <= cnt;
        capf[i] <= ev[i] | (capf[i] & !(wr_en && addr == 4'd9 && !wdata[i]));
      end
      if (wr_en) begin
        case (addr)
          4'd0: {cmp_clr, cap_clr, rld_en, mode, run} <= wdata[4:0];
          4'd1: begin div <= wdata[2:0]; trig <= wdata[5:4]; end
          4'd4: rld[7:0]  <= wdata;
          4'd5: rld[15:8] <= wdata;
          4'd6: ccfg[0] <= wdata[3:0];
          4'd7: ccfg[1] <= wdata[3:0];
          4'd8: ccfg[2] <= wdata[3:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      4'd0:    rdata = {tflag, 2'b00, cmp_clr, cap_clr, rld_en, mode, run};
      4'd1:    rdata = {2'b00, trig, 1'b0, div};
      4'd2:    rdata = cnt[7:0];
      4'd3:    rdata = cnt[15:8];
      4'd4:    rdata = rld[7:0];
      4'd5:    rdata = rld[15:8];
      4'd6:    rdata = {4'h0, ccfg[0]};
      4'd7:    rdata = {4'h0, ccfg[1]};
      4'd8:    rdata = {4'h0, ccfg[2]};
      4'd9:    rdata = {5'h00, capf};
      4'd10:   rdata = capv[0][7:0];
      4'd11:   rdata = capv[0][15:8];
      4'd12:   rdata = capv[1][7:0];
      4'd13:   rdata = capv[1][15:8];
      4'd14:   rdata = capv[2][7:0];
      default: rdata = capv[2][15:8];
    endcase
  end

  assign tmr_flag = tflag;
  assign cap_flag = capf;

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt && ev == 3'b000) |=> $stable(cnt));
  a_r3_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && tick && cnt == 16'hFFFF && !wr_cnt && ev == 3'b000) |=> tmr_flag);
  a_r5_capture_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_clr && ev != 3'b000 && !wr_cnt) |=> (cnt == 16'h0000));
  a_r7_compare_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && cmp_clr && tick && cnt == rld && !wr_cnt) |=> (cnt == 16'h0000));
  a_r8_capture_latch: assert property (@(posedge clk) disable iff (!rst_n)
    ev[0] |=> (cap_flag[0] && capv[0] == $past(cnt)));
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_flag && !(wr_en && addr == 4'd0 && !wdata[7])) |=> tmr_flag);
endmodule

// File: tb/test_rcap_timer.sv
module test_rcap_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'd0;
  logic [2:0] cap_in = 3'b000;
  logic [7:0] rdata;
  logic       tmr_flag;
  logic [2:0] cap_flag;

  always #4 clk = ~clk;

  rcap_timer i_rcap_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cap_in(cap_in), .tmr_flag(tmr_flag), .cap_flag(cap_flag)
  );

  int compared = 0, mismatched = 0, cyc = 0;
  string req = "R1";

  // behavioural reference state
  bit m_run, m_mode, m_rlden, m_capclr, m_cmpclr, m_tf;
  int m_div, m_trig, m_pre;
  int m_cnt, m_rld;
  int m_cfg [3];
  int m_cap [3];
  bit m_cf [3];
  bit m_s1 [3], m_s2 [3], m_lvl [3];
  int m_stab [3];

  function automatic int ratio(int d);
    int t [8] = '{1, 4, 16, 32, 64, 128, 256, 512};
    return t[d];
  endfunction

  function automatic int mread(int a);
    case (a)
      0: return (m_tf << 7) | (m_cmpclr << 4) | (m_capclr << 3) | (m_rlden << 2) | (m_mode << 1) | m_run;
      1: return (m_trig << 4) | m_div;
      2: return m_cnt % 256;
      3: return m_cnt / 256;
      4: return m_rld % 256;
      5: return m_rld / 256;
      6, 7, 8: return m_cfg[a-6];
      9: return (m_cf[2] << 2) | (m_cf[1] << 1) | m_cf[0];
      default: return (a % 2 == 0) ? m_cap[(a-10)/2] % 256 : m_cap[(a-10)/2] / 256;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_run, m_mode, m_rlden, m_capclr, m_cmpclr, m_tf} = '0;
      m_div = 0; m_trig = 0; m_pre = 0; m_cnt = 0; m_rld = 0;
      for (int c = 0; c < 3; c++) begin
        m_cfg[c] = 0; m_cap[c] = 0; m_cf[c] = 0;
        m_s1[c] = 0; m_s2[c] = 0; m_lvl[c] = 0; m_stab[c] = 4;
      end
    end else begin
      bit ev [3];
      bit nl [3];
      bit any, tick, fset;
      int ncnt;
      bit wa;
      any = 0;
      for (int c = 0; c < 3; c++) begin
        bit en, fl;
        int e;
        en = m_cfg[c][0]; fl = m_cfg[c][1]; e = (m_cfg[c] >> 2) & 3;
        nl[c] = (fl && m_stab[c] < 4) ? m_lvl[c] : m_s2[c];
        ev[c] = en && ((e == 0 && m_lvl[c] && !nl[c]) || (e == 1 && !m_lvl[c] && nl[c]) ||
                       (e == 2 && m_lvl[c] != nl[c]));
        any |= ev[c];
      end
      tick = m_run && (m_pre + 1 >= ratio(m_div));
      fset = 0;
      ncnt = m_cnt;
      wa = wr_en && (addr == 2 || addr == 3);
      if (wa) begin
        if (addr == 2) ncnt = (m_cnt & 'hFF00) | wdata;
        else ncnt = (m_cnt & 'h00FF) | (wdata << 8);
      end else if (m_capclr && any) ncnt = 0;
      else if (!m_mode && m_rlden && m_trig != 0 && ev[m_trig-1]) ncnt = m_rld;
      else if (tick) begin
        if (!m_mode) begin
          if (m_cnt == 'hFFFF) begin fset = 1; ncnt = (m_rlden && m_trig == 0) ? m_rld : 0; end
          else ncnt = m_cnt + 1;
        end else begin
          ncnt = (m_cmpclr && m_cnt == m_rld) ? 0 : (m_cnt + 1) % 65536;
          fset = (ncnt == m_rld);
        end
      end
      m_pre = (!m_run || tick) ? 0 : (m_pre + 1) % 512;
      m_tf = fset || (m_tf && !(wr_en && addr == 0 && !wdata[7]));
      for (int c = 0; c < 3; c++) begin
        if (ev[c]) m_cap[c] = m_cnt;
        m_cf[c] = ev[c] || (m_cf[c] && !(wr_en && addr == 9 && !wdata[c]));
      end
      m_cnt = ncnt;
      if (wr_en) begin
        case (addr)
          0: {m_cmpclr, m_capclr, m_rlden, m_mode, m_run} = wdata[4:0];
          1: begin m_div = wdata[2:0]; m_trig = wdata[5:4]; end
          4: m_rld = (m_rld & 'hFF00) | wdata;
          5: m_rld = (m_rld & 'h00FF) | (wdata << 8);
          6, 7, 8: m_cfg[addr-6] = wdata[3:0];
          default: ;
        endcase
      end
      for (int c = 0; c < 3; c++) begin
        m_lvl[c] = nl[c];
        m_stab[c] = (m_s1[c] == m_s2[c]) ? ((m_stab[c] < 4) ? m_stab[c] + 1 : 4) : 1;
        m_s2[c] = m_s1[c];
        m_s1[c] = cap_in[c];
      end
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    compared++;
    if (rdata !== 8'(mread(addr)) || tmr_flag !== m_tf ||
        cap_flag !== {m_cf[2], m_cf[1], m_cf[0]}) begin
      mismatched++;
      $display("FAIL %s cycle %0d addr %0d: rdata=%02h flag=%b cflags=%b, expected rdata=%02h flag=%b cflags=%b%b%b",
               req, cyc, addr, rdata, tmr_flag, cap_flag, 8'(mread(addr)), m_tf, m_cf[2], m_cf[1], m_cf[0]);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      addr = 4'(cyc % 16);
      step();
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; addr = 4'(a); wdata = 8'(d);
    step();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired in %s", req);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req = "R1"; idle(20);
    req = "R11";
    wr(4, 'h34); wr(5, 'h12); wr(1, 'h35); wr(6, 'h0B); wr(7, 'h06); wr(8, 'h0D); idle(20);
    wr(1, 0); wr(6, 0); wr(7, 0); wr(8, 0);
    req = "R2";
    wr(2, 0); wr(3, 0); wr(0, 'h01); idle(40);
    wr(1, 'h01); idle(60);
    wr(1, 'h07); idle(1100);
    wr(0, 'h00); idle(30);
    req = "R3";
    wr(2, 'hF0); wr(3, 'hFF); wr(1, 0); wr(0, 'h05); idle(40);
    wr(0, 'h01); wr(2, 'hF0); wr(3, 'hFF); idle(40);
    req = "R10";
    wr(0, 'h81); idle(3); wr(0, 'h01); idle(3);
    wr(0, 'h00); wr(2, 'hFE); wr(3, 'hFF); wr(0, 'h01);
    addr = 4'd0; step();
    wr(0, 'h01);
    idle(3); wr(0, 'h01); idle(3);
    req = "R8";
    wr(6, 'h01); wr(7, 'h05); wr(8, 'h09);
    cap_in = 3'b111; idle(8); cap_in = 3'b000; idle(8);
    wr(9, 'h00); idle(2);
    cap_in = 3'b111; idle(8); cap_in = 3'b000; idle(8);
    wr(9, 'h07); idle(2); wr(9, 'h00);
    wr(8, 'h0D); wr(6, 'h00);
    cap_in = 3'b101; idle(8); cap_in = 3'b000; idle(20);
    req = "R4";
    wr(4, 'h00); wr(5, 'h40); wr(0, 'h05);
    wr(1, 'h10); wr(6, 'h05); idle(5); cap_in = 3'b001; idle(8); cap_in = 3'b000; idle(8);
    wr(1, 'h20); idle(5); cap_in = 3'b010; idle(8); cap_in = 3'b000; idle(8);
    wr(1, 'h30); idle(5); cap_in = 3'b100; idle(8); cap_in = 3'b000; idle(8);
    req = "R5";
    wr(1, 'h10); wr(0, 'h0D); idle(5);
    cap_in = 3'b001; idle(8); cap_in = 3'b000; idle(8);
    cap_in = 3'b100; idle(8); cap_in = 3'b000; idle(8);
    req = "R9";
    wr(0, 'h01); wr(9, 'h00); wr(6, 'h07); idle(6);
    cap_in = 3'b001; idle(2); cap_in = 3'b000; idle(12);
    cap_in = 3'b001; idle(6); cap_in = 3'b000; idle(12);
    req = "R6";
    wr(6, 'h00); wr(4, 'h10); wr(5, 'h00); wr(0, 'h02); wr(2, 0); wr(3, 0);
    wr(0, 'h00); wr(0, 'h03); idle(40);
    req = "R7";
    wr(0, 'h13); wr(2, 0); idle(60);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule